// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects interrupt requests from on-chip peripherals into a sticky status register. It drives a single level-sensitive interrupt line to the processor. Each source raises its request with a pulse one clock wide. The pulse sets the matching status bit, and the bit stays set until software acknowledges it.

Software reaches the block over a simple register bus. The bus offers 16-bit and 32-bit accesses and decodes two word offsets: the status register at 0x070 and the mask register at 0x074. Software acknowledges interrupts by writing the status register. The written value is combined with the current status by a bitwise AND, so a 0 in the written value clears that bit and a 1 leaves it as it was.

The mask register selects which status bits may drive the interrupt line. A change to the mask takes effect on the output in the same clock as the write. The number of implemented source bits is a parameter and defaults to eleven. Three source bits are fixed by use: bit 3 for the DMA engine, bit 7 for the serial port and bit 9 for the sound unit.

Top module: `irq_status_ctrl`

## Requirements
- R1: While reset is high, status, mask and the interrupt output all become 0.
- R2: A pulse on source input bit i sets status bit i at the next clock edge, and the bit stays set until it is acknowledged. Bit 3 is the DMA engine, bit 7 the serial port and bit 9 the sound unit. A read at offset 0x070 returns the status register.
- R3: A status write (offset 0x070) stores status AND mask AND value, all taken before the write. Bits written as 0 are cleared, bits written as 1 are kept, and bits not enabled in the mask are cleared.
- R4: A source pulse in the same cycle as a status write that clears its bit takes precedence, so the bit remains set.
- R5: A mask write (offset 0x074) stores the written value, and a read at 0x074 returns it.
- R6: The interrupt output is a register equal to the OR of (status AND mask) as they stand after each clock edge. A mask write that unmasks a pending bit raises the output at that same edge, and a mask write that masks it lowers the output at that same edge.
- R7: Bits at and above the implemented source count read as 0 and ignore writes. A 16-bit access (wide = 0) writes only bits 15:0 and returns 0 in bits 31:16.
- R8: An access to any other address, including unaligned ones such as 0x071, leaves both registers unchanged and reads 0. A write with select low has no effect.
- R9: Reading the status register does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_addr | input | ADDR_W (12) | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| src_pulse | input | NUM_IRQ (11) | One-cycle interrupt requests, one bit per source |
| cpu_irq | output | 1 | Level interrupt to the processor |

## Verification
Register writes and source pulses change the status and mask registers at the next rising edge. The interrupt output changes at that same edge, because it is computed from the next-state values and is not taken from the registers one cycle later. Read data is combinational from the registers. Each read is therefore sampled 1 ns after its address is applied, before the edge, and the interrupt output is compared with a behavioural model at every falling edge. The model applies each cycle's write and pulses at the rising edge. The bench then checks read values and the interrupt output against it half a clock later. Directed checks use fixed values, and these include the cycle in which a mask write raises or drops the line.

// File: rtl/ism_pkg.sv
`timescale 1ns/1ps
package ism_pkg;
    localparam int BUS_W  = 32;
    localparam int HALF_W = 16;

    localparam logic [11:0] OFS_STATUS = 12'h070;
    localparam logic [11:0] OFS_MASK   = 12'h074;

    localparam int SRC_DMA    = 3;
    localparam int SRC_SERIAL = 7;
    localparam int SRC_SOUND  = 9;

    typedef enum logic [1:0] {
        TGT_NONE   = 2'd0,
        TGT_STATUS = 2'd1,
        TGT_MASK   = 2'd2
    } tgt_e;

    typedef struct packed {
        logic sel;
        logic we;
        logic wide;
    } bus_req_t;

    typedef struct packed {
        tgt_e tgt;
        logic wr;
        logic hi_lane;
    } acc_t;

    function automatic logic [BUS_W-1:0] half_mask(input logic wide);
        return wide ? {BUS_W{1'b1}} : {{(BUS_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    endfunction
endpackage

// File: rtl/ism_decode.sv
`timescale 1ns/1ps
module ism_decode
    import ism_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  bus_req_t          req,
    input  logic [ADDR_W-1:0] addr,
    output acc_t              acc
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);

    always_comb begin
        acc.tgt     = TGT_NONE;
        acc.wr      = req.sel && req.we;
        acc.hi_lane = req.wide;
        if (req.sel) begin
            if (addr == A_STATUS)    acc.tgt = TGT_STATUS;
            else if (addr == A_MASK) acc.tgt = TGT_MASK;
        end
    end
endmodule

// File: rtl/ism_regs.sv
`timescale 1ns/1ps
module ism_regs
    import ism_pkg::*;
#(
    parameter int NUM_IRQ = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stat_wr,
    input  logic               mask_wr,
    input  logic               hi_lane,
    input  logic [NUM_IRQ-1:0] wdata,
    input  logic [NUM_IRQ-1:0] src,
    output logic [NUM_IRQ-1:0] ack_val,
    output logic [NUM_IRQ-1:0] status_d,
    output logic [NUM_IRQ-1:0] mask_d,
    output logic [NUM_IRQ-1:0] status_q,
    output logic [NUM_IRQ-1:0] mask_q
);
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
        logic lane_on;
        if (i < HALF_W) begin : g_lo
            assign lane_on = 1'b1;
        end else begin : g_hi
            assign lane_on = hi_lane;
        end

        // Lanes not written keep their value: ack with 1, mask with old bit.
        assign ack_val[i]  = lane_on ? wdata[i] : 1'b1;
        assign status_d[i] = src[i] |
                             (stat_wr ? (status_q[i] & mask_q[i] & ack_val[i])
                                      : status_q[i]);
        assign mask_d[i]   = (mask_wr && lane_on) ? wdata[i] : mask_q[i];
    end

    if (NUM_IRQ <= HALF_W) begin : g_lane_unused
        logic unused_lane;
        assign unused_lane = hi_lane;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= status_d;
            mask_q   <= mask_d;
        end
    end
endmodule

// File: rtl/ism_irq.sv
`timescale 1ns/1ps
module ism_irq #(
    parameter int NUM_IRQ = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] status_d,
    input  logic [NUM_IRQ-1:0] mask_d,
    output logic               irq_q
);
    // Built from next-state values so a mask write acts at its own edge.
    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(status_d & mask_d);
    end
endmodule

// File: rtl/irq_status_ctrl.sv
`timescale 1ns/1ps
module irq_status_ctrl
    import ism_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NUM_IRQ = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic               bus_wide,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_IRQ-1:0] src_pulse,
    output logic               cpu_irq
);
    bus_req_t           req;
    acc_t               acc;
    logic               stat_wr;
    logic               mask_wr;
    logic [NUM_IRQ-1:0] ack_val;
    logic [NUM_IRQ-1:0] status_d;
    logic [NUM_IRQ-1:0] mask_d;
    logic [NUM_IRQ-1:0] status_q;
    logic [NUM_IRQ-1:0] mask_q;
    logic [BUS_W-1:0]   rd_full;

    assign req = '{sel: bus_sel, we: bus_we, wide: bus_wide};

    ism_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req  (req),
        .addr (bus_addr),
        .acc  (acc)
    );

    assign stat_wr = acc.wr && (acc.tgt == TGT_STATUS);
    assign mask_wr = acc.wr && (acc.tgt == TGT_MASK);

    ism_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .stat_wr  (stat_wr),
        .mask_wr  (mask_wr),
        .hi_lane  (acc.hi_lane),
        .wdata    (bus_wdata[NUM_IRQ-1:0]),
        .src      (src_pulse),
        .ack_val  (ack_val),
        .status_d (status_d),
        .mask_d   (mask_d),
        .status_q (status_q),
        .mask_q   (mask_q)
    );

    ism_irq #(.NUM_IRQ(NUM_IRQ)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .status_d (status_d),
        .mask_d   (mask_d),
        .irq_q    (cpu_irq)
    );

    always_comb begin
        unique case (acc.tgt)
            TGT_STATUS: rd_full = BUS_W'(status_q);
            TGT_MASK:   rd_full = BUS_W'(mask_q);
            default:    rd_full = '0;
        endcase
    end

    assign bus_rdata = rd_full & half_mask(acc.hi_lane);

    if (NUM_IRQ < BUS_W) begin : g_wdata_unused
        logic unused_wdata;
        assign unused_wdata = ^bus_wdata[BUS_W-1:NUM_IRQ];
    end
endmodule

// File: rtl/ism_checker.sv
`timescale 1ns/1ps
module ism_checker #(
    parameter int NUM_IRQ = 11
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_IRQ-1:0] src,
    input logic [NUM_IRQ-1:0] status_q,
    input logic [NUM_IRQ-1:0] mask_q,
    input logic               irq_o,
    input logic               stat_wr,
    input logic               mask_wr,
    input logic               wide,
    input logic [NUM_IRQ-1:0] wdata_lo,
    input logic [NUM_IRQ-1:0] ack_val
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (status_q == '0 && mask_q == '0 && !irq_o));

    assert_src_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (src != '0) |=> ((status_q & $past(src)) == $past(src)));

    assert_ack_and_R3: assert property (@(posedge clk) disable iff (rst)
        stat_wr |=> ((status_q & ~(($past(status_q) & $past(mask_q) & $past(ack_val))
                                   | $past(src))) == '0));

    assert_src_beats_ack_R4: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && src != '0) |=> ((status_q & $past(src)) == $past(src)));

    assert_mask_store_R5: assert property (@(posedge clk) disable iff (rst)
        (mask_wr && wide) |=> (mask_q == $past(wdata_lo)));

    assert_irq_level_R6: assert property (@(posedge clk) disable iff (rst)
        irq_o == |(status_q & mask_q));

    assert_status_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!stat_wr && src == '0) |=> $stable(status_q));

    assert_mask_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !mask_wr |=> $stable(mask_q));
endmodule

bind irq_status_ctrl ism_checker #(.NUM_IRQ(NUM_IRQ)) u_ism_chk (
    .clk      (clk),
    .rst      (rst),
    .src      (src_pulse),
    .status_q (status_q),
    .mask_q   (mask_q),
    .irq_o    (cpu_irq),
    .stat_wr  (stat_wr),
    .mask_wr  (mask_wr),
    .wide     (bus_wide),
    .wdata_lo (bus_wdata[NUM_IRQ-1:0]),
    .ack_val  (ack_val)
);

// File: tb/irq_status_ctrl_test.sv
`timescale 1ns/1ps
module irq_status_ctrl_test;
    localparam int N  = 11;
    localparam int AW = 12;
    localparam logic [31:0] IMPL = (32'h1 << N) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0, bus_we = 1'b0, bus_wide = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  src_pulse = '0;
    logic          cpu_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit chk_en = 1'b0;

    logic [31:0] m_stat = '0, m_mask = '0;
    logic        m_irq  = 1'b0;

    always #2.5 clk = ~clk;

    irq_status_ctrl #(.ADDR_W(AW), .NUM_IRQ(N)) uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .src_pulse(src_pulse), .cpu_irq(cpu_irq)
    );

    // Behavioural reference, updated at the same edge as the design.
    always @(posedge clk) begin : ref_model
        logic [31:0] ns, nm, av;
        if (rst) begin
            m_stat = '0; m_mask = '0; m_irq = 1'b0;
        end else begin
            ns = m_stat;
            nm = m_mask;
            if (bus_sel && bus_we && bus_addr == 12'h070) begin
                av = bus_wide ? bus_wdata : {16'hFFFF, bus_wdata[15:0]};
                ns = m_stat & m_mask & av;
            end
            if (bus_sel && bus_we && bus_addr == 12'h074)
                nm = (bus_wide ? bus_wdata : {m_mask[31:16], bus_wdata[15:0]}) & IMPL;
            ns = (ns | 32'(src_pulse)) & IMPL;
            m_stat = ns;
            m_mask = nm;
            m_irq  = |(ns & nm);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en) chk("R6 irq vs model", 32'(cpu_irq), 32'(m_irq));
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic idle();
        bus_sel = 1'b0; bus_we = 1'b0; bus_wide = 1'b0;
        bus_addr = '0; bus_wdata = '0; src_pulse = '0;
    endtask

    task automatic wr(input logic sel, input logic wide, input logic [AW-1:0] a,
                      input logic [31:0] d, input logic [N-1:0] s);
        bus_sel = sel; bus_we = 1'b1; bus_wide = wide;
        bus_addr = a; bus_wdata = d; src_pulse = s;
        @(negedge clk);
        idle();
    endtask

    task automatic pulse(input logic [N-1:0] s);
        src_pulse = s;
        @(negedge clk);
        idle();
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic wide, output logic [31:0] v);
        logic [31:0] exp;
        bus_sel = 1'b1; bus_we = 1'b0; bus_wide = wide; bus_addr = a;
        #1;
        v = bus_rdata;
        exp = (a == 12'h070) ? m_stat : (a == 12'h074) ? m_mask : 32'h0;
        if (!wide) exp = exp & 32'h0000FFFF;
        chk("R2/R5 read vs model", v, exp);
        @(negedge clk);
        idle();
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        chk("R1 irq low in reset", 32'(cpu_irq), 32'h0);
        rst = 1'b0;
        chk_en = 1'b1;
        rd(12'h070, 1'b1, v); chk("R1 status after reset", v, 32'h0);
        rd(12'h074, 1'b1, v); chk("R1 mask after reset", v, 32'h0);

        pulse(11'h008);
        rd(12'h070, 1'b1, v); chk("R2 DMA bit 3 set", v, 32'h008);
        pulse(11'h280);
        rd(12'h070, 1'b1, v); chk("R2 serial and sound bits", v, 32'h288);
        chk("R6 no irq while masked", 32'(cpu_irq), 32'h0);

        wr(1'b1, 1'b1, 12'h074, 32'h0000_0088, '0);
        chk("R6 irq raised by mask write at once", 32'(cpu_irq), 32'h1);
        rd(12'h074, 1'b1, v); chk("R5 mask readback", v, 32'h088);

        wr(1'b1, 1'b1, 12'h070, 32'hFFFF_FFFF, '0);
        rd(12'h070, 1'b1, v); chk("R3 unmasked bit 9 cleared", v, 32'h088);
        wr(1'b1, 1'b1, 12'h070, 32'hFFFF_FFF7, '0);
        rd(12'h070, 1'b1, v); chk("R3 zero acks bit 3", v, 32'h080);

        wr(1'b1, 1'b1, 12'h070, 32'h0, 11'h080);
        rd(12'h070, 1'b1, v); chk("R4 pulse wins over ack", v, 32'h080);
        chk("R4 irq stays high", 32'(cpu_irq), 32'h1);
        wr(1'b1, 1'b1, 12'h070, 32'h0, '0);
        chk("R6 irq drops after ack", 32'(cpu_irq), 32'h0);

        wr(1'b1, 1'b1, 12'h074, 32'hFFFF_FFFF, '0);
        rd(12'h074, 1'b1, v); chk("R7 unimplemented bits read zero", v, 32'h7FF);
        rd(12'h074, 1'b0, v); chk("R7 16-bit read", v, 32'h7FF);
        wr(1'b1, 1'b0, 12'h074, 32'hABCD_0003, '0);
        rd(12'h074, 1'b1, v); chk("R7 16-bit mask write", v, 32'h003);

        pulse(11'h001);
        chk("R6 irq from pending unmasked bit", 32'(cpu_irq), 32'h1);
        wr(1'b1, 1'b1, 12'h074, 32'h0, '0);
        chk("R6 mask write lowers irq at once", 32'(cpu_irq), 32'h0);
        wr(1'b1, 1'b1, 12'h074, 32'h1, '0);
        chk("R6 mask write raises irq at once", 32'(cpu_irq), 32'h1);

        wr(1'b1, 1'b1, 12'h078, 32'h0, '0);
        wr(1'b1, 1'b1, 12'h071, 32'h0, '0);
        wr(1'b0, 1'b1, 12'h070, 32'h0, '0);
        wr(1'b1, 1'b1, 12'h075, 32'h0, '0);
        rd(12'h070, 1'b1, v); chk("R8 stray writes ignored (status)", v, 32'h001);
        rd(12'h074, 1'b1, v); chk("R8 stray writes ignored (mask)", v, 32'h001);
        rd(12'h078, 1'b1, v); chk("R8 other offset reads zero", v, 32'h0);

        rd(12'h070, 1'b1, v);
        rd(12'h070, 1'b1, v); chk("R9 read does not clear", v, 32'h001);

        for (int k = 0; k < 600; k++) begin
            int op;
            logic [N-1:0] s;
            op = $urandom_range(0, 5);
            s  = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
            case (op)
                0: pulse(s);
                1: wr(1'b1, 1'($urandom), 12'h070, $urandom, s);
                2: wr(1'b1, 1'($urandom), 12'h074, $urandom, s);
                3: rd(12'h070, 1'($urandom), v);
                4: rd(12'h074, 1'($urandom), v);
                default: wr(1'b1, 1'b1, 12'h070, 32'hFFFF_FFFF, s);
            endcase
        end

        rst = 1'b1;
        @(negedge clk);
        chk("R1 irq cleared by reset", 32'(cpu_irq), 32'h0);
        rst = 1'b0;
        rd(12'h070, 1'b1, v); chk("R1 status cleared again", v, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule